// File: doc/BRIEF.md
# Shifted-Operand AND Stage with Condition Flags

This block is one datapath stage of a 32-bit processor core. It takes two source operands and an encoded shift specification. It shifts or rotates the second operand and ANDs the shifted value with the first operand. The result is registered and presented on an output stream. When flag setting is enabled, the stage also updates registered negative, zero and carry flags. The carry flag comes from the shifter, not from an adder, and the overflow flag is never altered.

Two instruction formats feed the stage through a small front end. In the wide format, a 2-bit shift type is combined with a 5-bit amount that is split into an upper 3-bit part and a lower 2-bit part, and flag setting comes from an explicit bit. In the narrow format, no shift is applied, and flags are set only when the operation is not inside a conditional block. Register-file access and condition evaluation are outside this block.

Operations enter on a valid/ready input and leave on a valid/ready output through a single output register. While the output is stalled, the stage accepts nothing. A new operation can enter in the same cycle that the held result is taken. The flags change only at the edge where an operation is accepted, so the next accepted operation already sees the new carry.

Top module: `andshift_stage`

## Requirements
- R1: In the wide format, shift type 2'b00 selects logical left, 2'b01 logical right, 2'b10 arithmetic right and 2'b11 rotate right, each by the 5-bit amount {amt_hi, amt_lo} when that amount is in the range 1 to 31.
- R2: For logical right and arithmetic right, an amount field of 0 means a shift by 32. Logical right by 32 gives zero with carry equal to operand bit 31. Arithmetic right by 32 fills every bit with operand bit 31, and the carry also equals bit 31.
- R3: Rotate right with an amount field of 0 is a one-bit rotate through carry: the current C flag enters bit 31, and operand bit 0 becomes the shifter carry.
- R4: Logical left with an amount field of 0 passes the operand unchanged, and the shifter carry equals the current C flag.
- R5: For a shift by n ≥ 1, the shifter carry is the last bit shifted out. For a rotate right by n ≥ 1, the shifter carry is bit 31 of the rotated value.
- R6: out_result equals op_a AND the shifted op_b. It is registered one cycle after acceptance.
- R7: When an accepted operation has flag setting enabled, N becomes result bit 31, Z becomes 1 exactly when the result is zero, C becomes the shifter carry, and V keeps its value.
- R8: In the wide format (in_narrow=0), flag setting is enabled exactly when in_setf=1.
- R9: In the narrow format (in_narrow=1), op_b is used unshifted with carry equal to the current C, and in_stype, amt_hi, amt_lo and in_setf are ignored. Flags are set exactly when in_cond=0.
- R10: in_ready = !out_valid || out_ready. An operation is accepted when in_valid && in_ready. While out_valid=1 and out_ready=0, out_valid and out_result hold.
- R11: A synchronous active-high reset clears out_valid, out_result and all four flags.
- R12: N, Z and C do not change in any cycle with no accepted operation, or when the accepted operation has flag setting disabled. V never changes after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Stage can accept an operation |
| in_narrow | input | 1 | 1 = narrow format, 0 = wide format |
| in_cond | input | 1 | Narrow format: operation is inside a conditional block |
| in_setf | input | 1 | Wide format: enable flag setting |
| in_stype | input | 2 | Shift type (wide format) |
| amt_hi | input | 3 | Upper part of the shift amount field |
| amt_lo | input | 2 | Lower part of the shift amount field |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand (shifted) |
| out_valid | output | 1 | Result held on out_result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | AND result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag (held) |

## Verification
Two functions can act in the same cycle. At one edge, the stage commits a flag update and drains a held result. In the next cycle, the following operation reads that committed carry, either through a zero-amount left shift or through a rotate through carry. The bench provokes this in two ways. It sends back-to-back operations in which the first sets C and the second is a rotate through carry or a narrow operation. It also holds out_ready low while a second operation waits, then releases it. The results, the bit 31 injected by the rotate, and the flags are each compared against a bench model that carries its own copy of C.

// File: rtl/andshift_pkg.sv
package andshift_pkg;
  typedef enum logic [1:0] {
    ST_LSL = 2'b00,
    ST_LSR = 2'b01,
    ST_ASR = 2'b10,
    ST_ROR = 2'b11
  } stype_e;

  typedef enum logic [2:0] {
    K_LSL,
    K_LSR,
    K_ASR,
    K_ROR,
    K_RRX
  } shkind_e;
endpackage

// File: rtl/andshift_decode.sv
module andshift_decode
  import andshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic             narrow,
  input  logic             in_cond,
  input  logic             setf,
  input  logic [1:0]       stype,
  input  logic [AMT_W-3:0] amt_hi,
  input  logic [1:0]       amt_lo,
  output shkind_e          kind,
  output logic [AMT_W:0]   amt,
  output logic             setf_eff
);
  localparam logic [AMT_W:0] FULL = (AMT_W+1)'(DATA_W);

  logic [AMT_W-1:0] field;
  logic             fzero;

  assign field = {amt_hi, amt_lo};
  assign fzero = (field == '0);

  always_comb begin
    kind     = K_LSL;
    amt      = '0;
    setf_eff = setf;
    if (narrow) begin
      kind     = K_LSL;
      amt      = '0;
      setf_eff = !in_cond;
    end else begin
      unique case (stype_e'(stype))
        ST_LSL: begin kind = K_LSL; amt = {1'b0, field}; end
        ST_LSR: begin kind = K_LSR; amt = fzero ? FULL : {1'b0, field}; end
        ST_ASR: begin kind = K_ASR; amt = fzero ? FULL : {1'b0, field}; end
        ST_ROR: begin kind = fzero ? K_RRX : K_ROR; amt = {1'b0, field}; end
        default: begin kind = K_LSL; amt = '0; end
      endcase
    end
  end
endmodule

// File: rtl/andshift_barrel.sv
module andshift_barrel
  import andshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  shkind_e           kind,
  input  logic [AMT_W:0]    amt,
  input  logic              cin,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic [DATA_W:0] ext;

  always_comb begin
    ext  = '0;
    res  = b;
    cout = cin;
    unique case (kind)
      K_LSL: begin
        ext  = {1'b0, b} << amt;
        res  = ext[DATA_W-1:0];
        cout = (amt == '0) ? cin : ext[DATA_W];
      end
      K_LSR: begin
        ext  = {b, 1'b0} >> amt;
        res  = ext[DATA_W:1];
        cout = ext[0];
      end
      K_ASR: begin
        ext  = $signed({b, 1'b0}) >>> amt;
        res  = ext[DATA_W:1];
        cout = ext[0];
      end
      K_ROR: begin
        res  = (b >> amt) | (b << (DATA_W - int'(amt)));
        cout = res[DATA_W-1];
      end
      K_RRX: begin
        res  = {cin, b[DATA_W-1:1]};
        cout = b[0];
      end
      default: begin
        res  = b;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/andshift_flags.sv
module andshift_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      if (upd) begin
        flag_n <= res[DATA_W-1];
        flag_z <= (res == '0);
        flag_c <= cout;
      end
      flag_v <= flag_v;
    end
  end
endmodule

// File: rtl/andshift_stage.sv
module andshift_stage
  import andshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_narrow,
  input  logic              in_cond,
  input  logic              in_setf,
  input  logic [1:0]        in_stype,
  input  logic [AMT_W-3:0]  amt_hi,
  input  logic [1:0]        amt_lo,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  shkind_e           kind;
  logic [AMT_W:0]    amt;
  logic              setf_eff;
  logic [DATA_W-1:0] shifted;
  logic              sh_carry;
  logic [DATA_W-1:0] and_res;
  logic              fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign and_res  = op_a & shifted;

  andshift_decode #(.DATA_W(DATA_W)) u_dec (
    .narrow   (in_narrow),
    .in_cond  (in_cond),
    .setf     (in_setf),
    .stype    (in_stype),
    .amt_hi   (amt_hi),
    .amt_lo   (amt_lo),
    .kind     (kind),
    .amt      (amt),
    .setf_eff (setf_eff)
  );

  andshift_barrel #(.DATA_W(DATA_W)) u_sh (
    .kind (kind),
    .amt  (amt),
    .cin  (flag_c),
    .b    (op_b),
    .res  (shifted),
    .cout (sh_carry)
  );

  andshift_flags #(.DATA_W(DATA_W)) u_flg (
    .clk    (clk),
    .rst    (rst),
    .upd    (fire && setf_eff),
    .res    (and_res),
    .cout   (sh_carry),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_v (flag_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= and_res;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/andshift_stage_chk.sv
module andshift_stage_chk #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_narrow,
  input logic              in_setf,
  input logic [AMT_W-3:0]  amt_hi,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R12
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(flag_v));

  // R12
  flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable({flag_n, flag_z, flag_c}));

  // R7
  nz_track_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_narrow && in_setf) |=>
      (flag_z == (out_result == '0)) && (flag_n == out_result[DATA_W-1]));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !flag_n && !flag_z && !flag_c && !flag_v));

  // R8
  wide_noset_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_narrow && !in_setf) |=>
      $stable({flag_n, flag_z, flag_c}));

  logic unused_ok;
  assign unused_ok = ^amt_hi;
endmodule

bind andshift_stage andshift_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_narrow  (in_narrow),
  .in_setf    (in_setf),
  .amt_hi     (amt_hi),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .flag_v     (flag_v)
);

// File: tb/andshift_stage_bench.sv
module andshift_stage_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_narrow = 1'b0;
  logic        in_cond = 1'b0;
  logic        in_setf = 1'b0;
  logic [1:0]  in_stype = 2'b00;
  logic [2:0]  amt_hi = 3'b0;
  logic [1:0]  amt_lo = 2'b0;
  logic [31:0] op_a = 32'b0;
  logic [31:0] op_b = 32'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        exp_n = 1'b0, exp_z = 1'b0, exp_c = 1'b0;
  logic [31:0] exp_res = 32'b0;

  always #2 clk = ~clk;

  andshift_stage u_andshift_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_narrow(in_narrow), .in_cond(in_cond), .in_setf(in_setf),
    .in_stype(in_stype), .amt_hi(amt_hi), .amt_lo(amt_lo),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // reference: returns {carry, shifted}
  function automatic logic [32:0] ref_shift(input logic [31:0] b, input logic [1:0] st,
                                            input logic [4:0] f, input logic cin,
                                            input logic narrow);
    int n;
    logic [31:0] r;
    logic c;
    if (narrow) return {cin, b};
    n = (f == 5'd0) ? 32 : int'(f);
    case (st)
      2'b00: begin
        if (f == 5'd0) begin r = b; c = cin; end
        else begin r = b << f; c = b[32 - int'(f)]; end
      end
      2'b01: begin
        r = (n == 32) ? 32'b0 : (b >> n);
        c = b[n-1];
      end
      2'b10: begin
        for (int i = 0; i < 32; i++) r[i] = (i + n > 31) ? b[31] : b[i+n];
        c = b[n-1];
      end
      default: begin
        if (f == 5'd0) begin r = {cin, b[31:1]}; c = b[0]; end
        else begin
          for (int i = 0; i < 32; i++) r[i] = b[(i + int'(f)) % 32];
          c = r[31];
        end
      end
    endcase
    return {c, r};
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic nar,
                       input logic cond, input logic sf, input logic [1:0] st,
                       input logic [4:0] f);
    logic [32:0] sh;
    logic        sfe;
    in_valid = 1'b1; in_narrow = nar; in_cond = cond; in_setf = sf;
    in_stype = st; amt_hi = f[4:2]; amt_lo = f[1:0]; op_a = a; op_b = b;
    sh = ref_shift(b, st, f, exp_c, nar);
    exp_res = a & sh[31:0];
    sfe = nar ? !cond : sf;
    if (sfe) begin
      exp_n = exp_res[31];
      exp_z = (exp_res == 32'b0);
      exp_c = sh[32];
    end
  endtask

  task automatic check_out(input string tag);
    chk({tag, " result"}, out_result, exp_res);
    chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " N"}, {31'b0, flag_n}, {31'b0, exp_n});
    chk({tag, " Z"}, {31'b0, flag_z}, {31'b0, exp_z});
    chk({tag, " C"}, {31'b0, flag_c}, {31'b0, exp_c});
    chk({"R12 V held ", tag}, {31'b0, flag_v}, 32'd0);
  endtask

  task automatic do_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic nar, input logic cond, input logic sf,
                       input logic [1:0] st, input logic [4:0] f);
    @(negedge clk);
    out_ready = 1'b1;
    drive(a, b, nar, cond, sf, st, f);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R11 out_result", out_result, 32'd0);
    chk("R11 flags", {28'b0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    chk("R10 ready after reset", {31'b0, in_ready}, 32'd1);

    // R1 R2 R4 R5: every type at amount fields 0, 1, 31
    for (int st = 0; st < 4; st++) begin
      do_op("R1 R5 amt1", 32'hFFFF_FFFF, 32'h8000_0001, 1'b0, 1'b0, 1'b1, 2'(st), 5'd1);
      do_op("R1 R5 amt31", 32'hFFFF_FFFF, 32'hC000_0003, 1'b0, 1'b0, 1'b1, 2'(st), 5'd31);
      do_op("R2 R3 R4 amt0", 32'hFFFF_FFFF, 32'h8000_0001, 1'b0, 1'b0, 1'b1, 2'(st), 5'd0);
      do_op("R2 R3 R4 amt0 pos", 32'hFFFF_FFFF, 32'h7FFF_FFFE, 1'b0, 1'b0, 1'b1, 2'(st), 5'd0);
    end
    // R2 by 32 with negative operand: LSR zero, ASR all ones
    do_op("R2 lsr32", 32'hFFFF_FFFF, 32'h9000_0000, 1'b0, 1'b0, 1'b1, 2'b01, 5'd0);
    do_op("R2 asr32", 32'hFFFF_FFFF, 32'h9000_0000, 1'b0, 1'b0, 1'b1, 2'b10, 5'd0);
    // R3: set C then rotate through carry back to back
    do_op("R3 set C", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 2'b01, 5'd1);
    do_op("R3 rrx cin1", 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 2'b11, 5'd0);
    chk("R3 bit31 from C", {31'b0, out_result[31]}, 32'd1);
    // R4: left by 0 keeps C
    do_op("R4 lsl0 keeps C", 32'h0F0F_0F0F, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 2'b00, 5'd0);
    // R6 and zero result
    do_op("R6 zero result", 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, 1'b0, 1'b1, 2'b00, 5'd0);
    // R8: wide without flag setting leaves flags
    do_op("R8 noset", 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 2'b10, 5'd4);
    // R9: narrow ignores shift fields and in_setf; in_cond gates flags
    do_op("R9 narrow incond", 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 2'b11, 5'd7);
    do_op("R9 narrow outcond", 32'h8000_00FF, 32'hFFFF_0F0F, 1'b1, 1'b0, 1'b0, 2'b01, 5'd3);

    // R10: stall holds result; no acceptance while stalled
    @(negedge clk);
    out_ready = 1'b0;
    drive(32'hAAAA_5555, 32'h1, 1'b0, 1'b0, 1'b1, 2'b00, 5'd31);
    @(negedge clk);
    check_out("R10 first");
    begin
      logic [31:0] held;
      logic        hn, hz, hc;
      held = exp_res; hn = exp_n; hz = exp_z; hc = exp_c;
      drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 2'b11, 5'd0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R10 stalled ready", {31'b0, in_ready}, 32'd0);
        chk("R10 stalled result", out_result, held);
        chk("R12 stalled flags", {29'b0, flag_n, flag_z, flag_c}, {29'b0, hn, hz, hc});
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_out("R10 after release");
      @(negedge clk);
      chk("R10 drained", {31'b0, out_valid}, 32'd0);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      do_op("R1 R6 R7 random", $urandom, $urandom, 1'($urandom % 5 == 0),
            1'($urandom), 1'($urandom), 2'($urandom), 5'($urandom));
    end

    // R11 reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset again", {27'b0, out_valid, flag_n, flag_z, flag_c, flag_v}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule